// File: doc/BRIEF.md
# Ring Instruction Dispatcher with Circulating-Bus Allocation

This block sits at the centre of a ring of function units through which register values circulate. It accepts a stream of decoded instructions (class, opcode, up to two source registers, an optional destination register) over a valid/ready handshake. It visits the units one per cycle in the direction the register values flow. For each slot it produces an issue word: either the current instruction, with the indices of the circulating buses that carry its operands and its result, or a NOP.

Architectural registers are mapped onto a small set of buses. A source register that is already on a bus is read from that bus. Otherwise it takes the lowest-numbered free bus. A destination either takes over the bus of a source whose last reader this instruction is, or joins a bus already tied to that register, or takes a free bus. An instruction is held, and its slot given a NOP, when the unit in the current slot cannot run it or when too few buses are free. Instructions that write the program counter go only to the branch unit. The unit mix is set by parameters, with ALUs first, then memory units, then branch units.

Top module: `ring_dispatch`

## Requirements
- R1: After reset, the issue word shows a NOP for slot index NUM_UNITS-1, and no bus is bound, so the first instruction takes buses from index 0 upward.
- R2: Exactly one slot is produced per clock cycle. The slot index rises by one each cycle and wraps from the last unit to unit 0.
- R3: Unit kinds are encoded as ALU=0, MEM=1, BR=2, and an instruction's class uses the same encoding. An instruction is issued only to a unit whose kind equals its class. If `in_pcw` is 1, it is issued only to a branch unit. Any other unit gets a NOP while `in_ready` stays low.
- R4: Newly needed buses are taken lowest free index first, in the order source A, source B, destination. A disabled field reads as 0.
- R5: A register that is already bound to a bus reuses that bus. Two sources that name the same register share one bus, and no two bound buses ever hold the same register.
- R6: If a source carries its last-read flag, the destination takes over that source's bus, with source A preferred over source B.
- R7: Otherwise the destination uses the bus of a source that names the same register, or else the bus already bound to the destination register. Any other bus still holding that register is released.
- R8: A source bus whose last reader has issued becomes free, unless it is rebound to the destination. A freed bus is handed out again.
- R9: When the buses an instruction needs exceed the free buses, the slot gets a NOP, `in_ready` is low and the bus bindings do not change.
- R10: With `in_valid` low, every slot gets a NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Instruction taken this cycle |
| in_cls | input | 2 | Class: 0 ALU, 1 MEM, 2 BR |
| in_pcw | input | 1 | Instruction writes the program counter |
| in_opc | input | OPC_W | Opcode passed through |
| in_a_en | input | 1 | Source A used |
| in_a | input | REG_W | Source A register |
| in_a_last | input | 1 | Last read of source A |
| in_b_en | input | 1 | Source B used |
| in_b | input | REG_W | Source B register |
| in_b_last | input | 1 | Last read of source B |
| in_d_en | input | 1 | Destination used |
| in_d | input | REG_W | Destination register |
| out_slot | output | UNIT_W | Unit served by this issue word |
| out_nop | output | 1 | Issue word is a NOP |
| out_cls | output | 2 | Class of issued instruction |
| out_opc | output | OPC_W | Opcode of issued instruction |
| out_bus_a | output | BUS_W | Bus carrying source A |
| out_bus_b | output | BUS_W | Bus carrying source B |
| out_bus_d | output | BUS_W | Bus receiving the result |
| out_use | output | 3 | Enables {dest, B, A} |

## Verification
Directed sequences come first. A fresh table shows lowest-first allocation. A last-read source shows the result taking over its bus. A full bus set shows the stall and the NOP, and a program-counter writer shows that it passes the ALUs and waits for the branch slot. Two reads of one register show that a single bus is shared and that a bus freed earlier is handed out again. Random instruction mixes with many register collisions then separate class mismatches from bus shortages and from idle slots, and every issue word is compared with a bench model. When the free buses run low, the bench switches to rescue instructions that reuse a last-read bus, so the ring keeps making progress.

// File: rtl/rdsp_pkg.sv
package rdsp_pkg;

   typedef enum logic [1:0] {
      K_ALU = 2'd0,
      K_MEM = 2'd1,
      K_BR  = 2'd2
   } kind_e;

   // ring layout: ALUs first, then memory units, then branch units
   function automatic kind_e kind_at(input int idx, input int n_alu, input int n_mem);
      if (idx < n_alu)              return K_ALU;
      else if (idx < n_alu + n_mem) return K_MEM;
      else                          return K_BR;
   endfunction

endpackage

// File: rtl/rdsp_ring_slot.sv
module rdsp_ring_slot
   import rdsp_pkg::*;
#(
   parameter int NUM_ALU = 2,
   parameter int NUM_MEM = 1,
   parameter int NUM_BR  = 1,
   parameter int UNIT_N  = NUM_ALU + NUM_MEM + NUM_BR,
   parameter int UNIT_W  = (UNIT_N > 1) ? $clog2(UNIT_N) : 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        want_kind,
   output logic [UNIT_W-1:0] slot,
   output logic              match
);

   localparam logic [UNIT_W-1:0] LAST = UNIT_W'(UNIT_N - 1);

   logic [1:0] ktab [UNIT_N];

   for (genvar u = 0; u < UNIT_N; u++) begin : g_kind
      assign ktab[u] = 2'(kind_at(u, NUM_ALU, NUM_MEM));
   end

   assign match = (ktab[slot] == want_kind);

   always_ff @(posedge clk) begin
      if (!rst_n)            slot <= '0;
      else if (slot == LAST) slot <= '0;
      else                   slot <= slot + 1'b1;
   end

   assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (slot == LAST) |=> (slot == '0));

   assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (slot != LAST) |=> (slot == $past(slot) + 1'b1));

endmodule

// File: rtl/rdsp_bus_alloc.sv
module rdsp_bus_alloc #(
   parameter int NUM_BUS = 4,
   parameter int REG_W   = 4,
   parameter int BUS_W   = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             issue,
   input  logic             a_en,
   input  logic [REG_W-1:0] a_reg,
   input  logic             a_last,
   input  logic             b_en,
   input  logic [REG_W-1:0] b_reg,
   input  logic             b_last,
   input  logic             d_en,
   input  logic [REG_W-1:0] d_reg,
   output logic             fit,
   output logic [BUS_W-1:0] bus_a,
   output logic [BUS_W-1:0] bus_b,
   output logic [BUS_W-1:0] bus_d
);

   logic [NUM_BUS-1:0] live, live_n;
   logic [REG_W-1:0]   breg   [NUM_BUS];
   logic [REG_W-1:0]   breg_n [NUM_BUS];

   logic             hit_a, hit_b, hit_d, same_ab, need_a, need_b, need_d;
   logic [BUS_W-1:0] idx_a, idx_b, idx_d, fr0, fr1, fr2;
   int               nf, n_src, n_new;

   // lookup of existing bindings and the first three free buses
   always_comb begin
      hit_a = 1'b0; hit_b = 1'b0; hit_d = 1'b0;
      idx_a = '0;   idx_b = '0;   idx_d = '0;
      fr0 = '0; fr1 = '0; fr2 = '0;
      nf = 0;
      for (int j = 0; j < NUM_BUS; j++) begin
         if (live[j]) begin
            if (breg[j] == a_reg) begin hit_a = 1'b1; idx_a = BUS_W'(j); end
            if (breg[j] == b_reg) begin hit_b = 1'b1; idx_b = BUS_W'(j); end
            if (breg[j] == d_reg) begin hit_d = 1'b1; idx_d = BUS_W'(j); end
         end else begin
            if (nf == 0)      fr0 = BUS_W'(j);
            else if (nf == 1) fr1 = BUS_W'(j);
            else if (nf == 2) fr2 = BUS_W'(j);
            nf = nf + 1;
         end
      end
   end

   // operand and result bus choice
   always_comb begin
      same_ab = a_en && b_en && (a_reg == b_reg);
      need_a  = a_en && !hit_a;
      need_b  = b_en && !hit_b && !same_ab;
      bus_a   = hit_a ? idx_a : fr0;
      if (hit_b)        bus_b = idx_b;
      else if (same_ab) bus_b = bus_a;
      else              bus_b = need_a ? fr1 : fr0;
      n_src  = int'(need_a) + int'(need_b);
      need_d = 1'b0;
      if (!d_en)                            bus_d = '0;
      else if (a_en && a_last)              bus_d = bus_a;
      else if (b_en && b_last)              bus_d = bus_b;
      else if (a_en && (d_reg == a_reg))    bus_d = bus_a;
      else if (b_en && (d_reg == b_reg))    bus_d = bus_b;
      else if (hit_d)                       bus_d = idx_d;
      else begin
         need_d = 1'b1;
         bus_d  = (n_src == 0) ? fr0 : (n_src == 1) ? fr1 : fr2;
      end
      n_new = n_src + int'(need_d);
      fit   = (n_new <= nf);
   end

   // binding table update
   always_comb begin
      live_n = live;
      for (int j = 0; j < NUM_BUS; j++) breg_n[j] = breg[j];
      if (issue) begin
         if (need_a) begin live_n[bus_a] = 1'b1; breg_n[bus_a] = a_reg; end
         if (need_b) begin live_n[bus_b] = 1'b1; breg_n[bus_b] = b_reg; end
         if (a_en && a_last) live_n[bus_a] = 1'b0;
         if (b_en && b_last) live_n[bus_b] = 1'b0;
         if (d_en) begin
            for (int j = 0; j < NUM_BUS; j++)
               if ((BUS_W'(j) != bus_d) && live_n[j] && (breg_n[j] == d_reg))
                  live_n[j] = 1'b0;
            live_n[bus_d] = 1'b1;
            breg_n[bus_d] = d_reg;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         live <= '0;
         for (int j = 0; j < NUM_BUS; j++) breg[j] <= '0;
      end else begin
         live <= live_n;
         for (int j = 0; j < NUM_BUS; j++) breg[j] <= breg_n[j];
      end
   end

   for (genvar i = 0; i < NUM_BUS; i++) begin : g_uniq_i
      for (genvar k = i + 1; k < NUM_BUS; k++) begin : g_uniq_k
         assert_unique_bind_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (live[i] && live[k]) |-> (breg[i] != breg[k]));
      end
   end

   assert_dst_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && d_en) |=> (live[$past(bus_d)] && (breg[$past(bus_d)] == $past(d_reg))));

   assert_last_freed_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && a_en && a_last && !d_en) |=> !live[$past(bus_a)]);

   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !issue |=> $stable(live));

   assert_fit_R9: assert property (@(posedge clk) disable iff (!rst_n)
      issue |-> fit);

endmodule

// File: rtl/ring_dispatch.sv
module ring_dispatch
   import rdsp_pkg::*;
#(
   parameter int NUM_ALU  = 2,
   parameter int NUM_MEM  = 1,
   parameter int NUM_BR   = 1,
   parameter int NUM_BUS  = 4,
   parameter int NUM_REGS = 16,
   parameter int OPC_W    = 6,
   parameter int UNIT_N   = NUM_ALU + NUM_MEM + NUM_BR,
   parameter int UNIT_W   = (UNIT_N > 1) ? $clog2(UNIT_N) : 1,
   parameter int BUS_W    = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1,
   parameter int REG_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [1:0]        in_cls,
   input  logic              in_pcw,
   input  logic [OPC_W-1:0]  in_opc,
   input  logic              in_a_en,
   input  logic [REG_W-1:0]  in_a,
   input  logic              in_a_last,
   input  logic              in_b_en,
   input  logic [REG_W-1:0]  in_b,
   input  logic              in_b_last,
   input  logic              in_d_en,
   input  logic [REG_W-1:0]  in_d,
   output logic [UNIT_W-1:0] out_slot,
   output logic              out_nop,
   output logic [1:0]        out_cls,
   output logic [OPC_W-1:0]  out_opc,
   output logic [BUS_W-1:0]  out_bus_a,
   output logic [BUS_W-1:0]  out_bus_b,
   output logic [BUS_W-1:0]  out_bus_d,
   output logic [2:0]        out_use
);

   if (NUM_BUS < 3) begin : g_bad_bus
      $error("ring_dispatch: NUM_BUS must be at least 3");
   end
   if (NUM_BR < 1) begin : g_bad_br
      $error("ring_dispatch: at least one branch unit is required");
   end
   if (UNIT_N < 2) begin : g_bad_ring
      $error("ring_dispatch: ring needs two or more units");
   end

   logic [1:0]        want;
   logic [UNIT_W-1:0] slot;
   logic              match, fit, fire;
   logic [BUS_W-1:0]  ba, bb, bd;

   assign want = in_pcw ? 2'(K_BR) : in_cls;

   rdsp_ring_slot #(
      .NUM_ALU (NUM_ALU),
      .NUM_MEM (NUM_MEM),
      .NUM_BR  (NUM_BR),
      .UNIT_N  (UNIT_N),
      .UNIT_W  (UNIT_W)
   ) u_ring (
      .clk       (clk),
      .rst_n     (rst_n),
      .want_kind (want),
      .slot      (slot),
      .match     (match)
   );

   assign fire     = in_valid && match && fit;
   assign in_ready = fire;

   rdsp_bus_alloc #(
      .NUM_BUS (NUM_BUS),
      .REG_W   (REG_W),
      .BUS_W   (BUS_W)
   ) u_alloc (
      .clk    (clk),
      .rst_n  (rst_n),
      .issue  (fire),
      .a_en   (in_a_en),
      .a_reg  (in_a),
      .a_last (in_a_last),
      .b_en   (in_b_en),
      .b_reg  (in_b),
      .b_last (in_b_last),
      .d_en   (in_d_en),
      .d_reg  (in_d),
      .fit    (fit),
      .bus_a  (ba),
      .bus_b  (bb),
      .bus_d  (bd)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_slot  <= UNIT_W'(UNIT_N - 1);
         out_nop   <= 1'b1;
         out_cls   <= '0;
         out_opc   <= '0;
         out_bus_a <= '0;
         out_bus_b <= '0;
         out_bus_d <= '0;
         out_use   <= '0;
      end else begin
         out_slot <= slot;
         out_nop  <= !fire;
         if (fire) begin
            out_cls   <= in_cls;
            out_opc   <= in_opc;
            out_bus_a <= in_a_en ? ba : '0;
            out_bus_b <= in_b_en ? bb : '0;
            out_bus_d <= in_d_en ? bd : '0;
            out_use   <= {in_d_en, in_b_en, in_a_en};
         end else begin
            out_cls   <= '0;
            out_opc   <= '0;
            out_bus_a <= '0;
            out_bus_b <= '0;
            out_bus_d <= '0;
            out_use   <= '0;
         end
      end
   end

   assert_ready_needs_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> in_valid);

   assert_kind_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!out_nop && (kind_at(int'(out_slot), NUM_ALU, NUM_MEM) != K_BR))
         |-> (out_cls == 2'(kind_at(int'(out_slot), NUM_ALU, NUM_MEM))));

   assert_idle_nop_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> out_nop);

   assert_slot_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (out_slot == (($past(out_slot) == UNIT_W'(UNIT_N - 1)) ? '0 : $past(out_slot) + 1'b1)));

endmodule

// File: tb/ring_dispatch_test.sv
module ring_dispatch_test;

   localparam int CLK_PERIOD = 10;
   localparam int NU = 4;
   localparam int NB = 4;
   localparam int WD_LIMIT = 150000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic       in_ready;
   logic [1:0] in_cls = '0;
   logic       in_pcw = 1'b0;
   logic [5:0] in_opc = '0;
   logic       in_a_en = 1'b0, in_a_last = 1'b0;
   logic       in_b_en = 1'b0, in_b_last = 1'b0;
   logic       in_d_en = 1'b0;
   logic [3:0] in_a = '0, in_b = '0, in_d = '0;
   logic [1:0] out_slot;
   logic       out_nop;
   logic [1:0] out_cls;
   logic [5:0] out_opc;
   logic [1:0] out_bus_a, out_bus_b, out_bus_d;
   logic [2:0] out_use;

   always #(CLK_PERIOD/2) clk = ~clk;

   ring_dispatch uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_cls(in_cls), .in_pcw(in_pcw), .in_opc(in_opc),
      .in_a_en(in_a_en), .in_a(in_a), .in_a_last(in_a_last),
      .in_b_en(in_b_en), .in_b(in_b), .in_b_last(in_b_last),
      .in_d_en(in_d_en), .in_d(in_d),
      .out_slot(out_slot), .out_nop(out_nop), .out_cls(out_cls), .out_opc(out_opc),
      .out_bus_a(out_bus_a), .out_bus_b(out_bus_b), .out_bus_d(out_bus_d), .out_use(out_use)
   );

   int n_chk = 0, n_err = 0, cyc = 0;
   bit done = 1'b0;

   // bench model of the binding table
   bit m_live [NB];
   int m_reg  [NB];
   int m_ptr = 0;
   bit e_rdy, last_rdy;
   int e_a, e_b, e_d;
   string cause;

   function automatic int kind_of(int u);
      if (u < 2) return 0;
      if (u < 3) return 1;
      return 2;
   endfunction

   function automatic int free_count();
      int c = 0;
      for (int j = 0; j < NB; j++) if (!m_live[j]) c++;
      return c;
   endfunction

   function automatic int find_bus(int r);
      for (int j = 0; j < NB; j++) if (m_live[j] && m_reg[j] == r) return j;
      return -1;
   endfunction

   task automatic chk(bit ok, string req, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // evaluates the current inputs against the model; fills e_* and cause
   task automatic predict(string tag);
      int fl [3];
      int nf = 0, ha, hb, hd, nsrc, tgt;
      bit na, nb2, nd, same;
      for (int j = 0; j < NB; j++)
         if (!m_live[j]) begin if (nf < 3) fl[nf] = j; nf++; end
      for (int k = nf; k < 3; k++) fl[k] = 0;
      ha = find_bus(int'(in_a)); hb = find_bus(int'(in_b)); hd = find_bus(int'(in_d));
      same = in_a_en && in_b_en && in_a == in_b;
      na = in_a_en && ha < 0;
      nb2 = in_b_en && hb < 0 && !same;
      e_a = (ha >= 0) ? ha : fl[0];
      e_b = (hb >= 0) ? hb : same ? e_a : (na ? fl[1] : fl[0]);
      nsrc = int'(na) + int'(nb2);
      nd = 1'b0; e_d = 0;
      if (in_d_en) begin
         if (in_a_en && in_a_last) e_d = e_a;
         else if (in_b_en && in_b_last) e_d = e_b;
         else if (in_a_en && in_d == in_a) e_d = e_a;
         else if (in_b_en && in_d == in_b) e_d = e_b;
         else if (hd >= 0) e_d = hd;
         else begin nd = 1'b1; e_d = fl[nsrc]; end
      end
      tgt = in_pcw ? 2 : int'(in_cls);
      if (!in_valid) begin e_rdy = 1'b0; cause = "R10"; end
      else if (kind_of(m_ptr) != tgt) begin e_rdy = 1'b0; cause = "R3"; end
      else if (nsrc + int'(nd) > nf) begin e_rdy = 1'b0; cause = "R9"; end
      else begin e_rdy = 1'b1; cause = tag; end
      if (e_rdy) begin
         if (na) begin m_live[e_a] = 1; m_reg[e_a] = int'(in_a); end
         if (nb2) begin m_live[e_b] = 1; m_reg[e_b] = int'(in_b); end
         if (in_a_en && in_a_last) m_live[e_a] = 0;
         if (in_b_en && in_b_last) m_live[e_b] = 0;
         if (in_d_en) begin
            for (int j = 0; j < NB; j++)
               if (j != e_d && m_live[j] && m_reg[j] == int'(in_d)) m_live[j] = 0;
            m_live[e_d] = 1; m_reg[e_d] = int'(in_d);
         end
      end
      if (!in_a_en) e_a = 0;
      if (!in_b_en) e_b = 0;
   endtask

   // one ring slot: called just after a falling edge with inputs driven
   task automatic step(string tag);
      int slot_exp;
      bit [5:0] opc_s = in_opc;
      bit [1:0] cls_s = in_cls;
      #1;
      slot_exp = m_ptr;
      predict(tag);
      chk(in_ready === e_rdy, cause, "in_ready", int'(in_ready), int'(e_rdy));
      @(posedge clk); #1;
      chk(out_slot == 2'(slot_exp), "R2", "out_slot", int'(out_slot), slot_exp);
      chk(out_nop == !e_rdy, cause, "out_nop", int'(out_nop), int'(!e_rdy));
      if (e_rdy) begin
         chk(out_cls == cls_s && out_opc == opc_s, "R3", "out_cls/opc",
             int'({out_cls, out_opc}), int'({cls_s, opc_s}));
         chk(out_bus_a == 2'(e_a), tag, "out_bus_a", int'(out_bus_a), e_a);
         chk(out_bus_b == 2'(e_b), tag, "out_bus_b", int'(out_bus_b), e_b);
         chk(out_bus_d == 2'(e_d), tag, "out_bus_d", int'(out_bus_d), e_d);
      end
      last_rdy = e_rdy;
      m_ptr = (m_ptr == NU - 1) ? 0 : m_ptr + 1;
   endtask

   task automatic drive(int cls, bit pcw, int opc, bit ae, int a, bit al,
                        bit be, int b, bit bl, bit de, int d);
      in_cls = 2'(cls); in_pcw = pcw; in_opc = 6'(opc);
      in_a_en = ae; in_a = 4'(a); in_a_last = al;
      in_b_en = be; in_b = 4'(b); in_b_last = bl;
      in_d_en = de; in_d = 4'(d);
   endtask

   // presents the driven instruction until taken; starts and ends at a falling edge
   task automatic send(string tag);
      in_valid = 1'b1;
      for (int k = 0; k < 40; k++) begin
         step(tag);
         if (last_rdy) break;
         @(negedge clk);
      end
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic idle(int n);
      in_valid = 1'b0;
      for (int k = 0; k < n; k++) begin
         step("R10");
         @(negedge clk);
      end
   endtask

   task automatic pick_random();
      int live_idx;
      if (free_count() < 3) begin
         live_idx = -1;
         for (int j = 0; j < NB; j++) if (m_live[j] && live_idx < 0 && ($urandom % 2 == 0)) live_idx = j;
         for (int j = 0; j < NB; j++) if (m_live[j] && live_idx < 0) live_idx = j;
         drive(int'($urandom % 3), 1'b0, int'($urandom % 64), 1'b1, m_reg[live_idx], 1'b1,
               1'b0, 0, 1'b0, bit'($urandom % 2), int'($urandom % 8));
      end else begin
         drive(int'($urandom % 3), ($urandom % 8) == 0, int'($urandom % 64),
               ($urandom % 4) != 0, int'($urandom % 8), ($urandom % 3) == 0,
               ($urandom % 3) != 0, int'($urandom % 8), ($urandom % 3) == 0,
               ($urandom % 4) != 0, int'($urandom % 8));
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > WD_LIMIT && !done) begin
         done = 1'b1;
         n_chk++; n_err++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, WD_LIMIT);
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7));
      for (int j = 0; j < NB; j++) begin m_live[j] = 0; m_reg[j] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(out_nop == 1'b1, "R1", "out_nop after reset", int'(out_nop), 1);
      chk(out_slot == 2'(NU - 1), "R1", "out_slot after reset", int'(out_slot), NU - 1);

      // R1/R4: fresh table, ALU r1+r2 -> r3 lands on buses 0,1,2
      drive(0, 0, 5, 1, 1, 0, 1, 2, 0, 1, 3);
      send("R4");
      chk(out_bus_a == 0 && out_bus_b == 1 && out_bus_d == 2, "R1", "fresh buses",
          int'({out_bus_a, out_bus_b, out_bus_d}), 6);

      // R6: r1 last-read, r4 new, result r5 takes over r1's bus 0
      drive(0, 0, 6, 1, 1, 1, 1, 4, 0, 1, 5);
      send("R6");
      chk(out_bus_a == 0 && out_bus_b == 3 && out_bus_d == 0, "R6", "reuse of last-read bus",
          int'({out_bus_a, out_bus_b, out_bus_d}), int'({2'd0, 2'd3, 2'd0}));

      // R9: table full (r5,r2,r3,r4); MEM r6 -> r7 needs two buses
      drive(1, 0, 7, 1, 6, 0, 0, 0, 0, 1, 7);
      in_valid = 1'b1;
      for (int k = 0; k < 5; k++) begin step("R9"); @(negedge clk); end
      in_valid = 1'b0;

      // R6: MEM reads r2 last, writes r6 onto bus 1
      drive(1, 0, 8, 1, 2, 1, 0, 0, 0, 1, 6);
      send("R6");

      // R3/R8: ALU writing the PC only on the branch unit; frees r3's bus 2
      drive(0, 1, 9, 1, 3, 1, 0, 0, 0, 0, 0);
      send("R3");
      chk(out_slot == 2'(NU - 1), "R3", "pc writer slot", int'(out_slot), NU - 1);

      // R5/R7: r5+r5 -> r5 stays on bus 0
      drive(0, 0, 10, 1, 5, 0, 1, 5, 0, 1, 5);
      send("R7");
      chk(out_bus_a == 0 && out_bus_b == 0 && out_bus_d == 0, "R7", "dst joins source bus",
          int'({out_bus_a, out_bus_b, out_bus_d}), 0);

      // R5/R8: r8 read twice shares the freed bus 2, result reuses it
      drive(0, 0, 11, 1, 8, 1, 1, 8, 0, 1, 9);
      send("R5");
      chk(out_bus_a == 2 && out_bus_b == 2 && out_bus_d == 2, "R8", "freed bus handed out again",
          int'({out_bus_a, out_bus_b, out_bus_d}), int'({2'd2, 2'd2, 2'd2}));

      idle(5);

      for (int n = 0; n < 600; n++) begin
         pick_random();
         send("R4");
         if ($urandom % 5 == 0) idle(1 + int'($urandom % 3));
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule